// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status

This block receives asynchronous serial frames on a single input line and stores each finished character in a two-entry receive queue. Every queue entry keeps the character together with its own framing, parity and overrun indications. The flags shown at the outputs always describe the oldest unread character. Software removes that character with a one-cycle read strobe.

A third finished character can wait in a holding register behind the full queue. When a new start bit is confirmed while the queue and the holding register are all occupied, the incoming character is lost. The next character that is stored is then marked with the overrun flag.

A free-running prescaler produces sampling ticks. The receiver takes either sixteen or eight ticks per bit. It accepts 5 to 9 data bits and optional even or odd parity, and it checks only the first stop bit. An address-filter mode discards every frame that does not carry an address mark. A receive interrupt request is raised while unread data is present and both enables are set.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `dataAvail`, `rxIrq`, `frameErr`, `parityErr`, `overrun`, `rxBit9` and `rxData` are all 0.
- R2: Data bits arrive LSB first after the start bit. `sizeSel` values 0,1,2,3,4 select 5,6,7,8,9 data bits; other values select 8. The character is right-aligned in `rxData` with the unused upper bits at 0. In 9-bit mode the ninth bit appears on `rxBit9`; in every other mode `rxBit9` is 0.
- R3: `frameErr` is 1 for a character whose first stop bit was sampled as 0, and 0 when that stop bit was 1.
- R4: Parity checking is enabled when `parityMode[1]`=1; `parityMode[0]`=1 selects odd parity and 0 selects even. The parity bit follows the last data bit. A parity error is recorded only when checking was enabled at the start of that character. With checking disabled, no parity bit is expected.
- R5: One sampling tick occurs every `prescale`+1 clocks. A bit lasts 16 ticks when `doubleSpeed`=0 and 8 ticks when `doubleSpeed`=1. In 16-tick mode the bit value is the majority of three samples around the bit centre; in 8-tick mode it is one centre sample.
- R6: The queue holds two characters, each with its own flags. The outputs show the oldest one, and a read strobe removes it and exposes the next.
- R7: A character that finishes while the queue is full waits in a holding register. It enters the queue on the next read, with no loss and with its order kept.
- R8: When a start bit is confirmed while the queue is full and the holding register is occupied, that incoming character is discarded and the stored characters stay unchanged. The next character stored afterwards shows `overrun`=1.
- R9: With `addrFilter`=1, a 9-bit frame whose ninth bit is 1 is stored, and a 9-bit frame whose ninth bit is 0 is discarded. In 5- to 8-bit modes every frame is discarded.
- R10: `rxIrq` is 1 exactly when `rxIntEnable`=1, `globalIntEnable`=1 and unread data is present.
- R11: A low pulse on the line that is shown high at the start-bit centre is ignored, and the receiver returns to waiting for a start bit.
- R12: A read strobe while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input line, idle high |
| prescale | input | 16 | Tick period minus one, in clocks |
| rxEnable | input | 1 | Receiver enable |
| parityMode | input | 2 | Bit 1 enables parity, bit 0 selects odd |
| sizeSel | input | 3 | Character size select |
| doubleSpeed | input | 1 | 8 ticks per bit instead of 16 |
| addrFilter | input | 1 | Discard frames that carry no address mark |
| rxIntEnable | input | 1 | Receive interrupt enable |
| globalIntEnable | input | 1 | Global interrupt enable |
| readStrobe | input | 1 | Removes the oldest character |
| rxData | output | 8 | Oldest character, low eight bits |
| rxBit9 | output | 1 | Ninth bit of the oldest character |
| frameErr | output | 1 | Framing error of the oldest character |
| parityErr | output | 1 | Parity error of the oldest character |
| overrun | output | 1 | Data was lost before the oldest character |
| dataAvail | output | 1 | Unread data present |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
A software read and the completion of a frame at the stop-bit sample can land in the same clock. This happens when two characters are already queued, because the read must free a slot and the finishing character must take it in that same cycle. The bench queues two characters and sends a third. It sweeps the read strobe across every clock of the third character's stop bit, so one pass places the read exactly on the completion cycle. After each pass, the second and third characters must come out in order, with clear flags and no overrun.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef struct packed {
    logic [8:0] data;
    logic       fe;
    logic       pe;
    logic       ovr;
  } rx_entry_t;

  typedef struct packed {
    logic       startOk;
    logic       dataStb;
    logic       parStb;
    logic       stopStb;
    logic       bitVal;
    logic [3:0] bitIdx;
    logic       parEn;
    logic       parOdd;
    logic       nineBit;
  } rx_strobe_t;

endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int PRESCALE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rxLine,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic                  rxEnable,
  input  logic [1:0]            parityMode,
  input  logic [2:0]            sizeSel,
  input  logic                  doubleSpeed,
  output rx_strobe_t            stb
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PARITY, S_STOP} rx_state_t;

  rx_state_t             state;
  logic [2:0]            syncReg;
  logic                  lineNow, linePrev, fallEdge;
  logic [PRESCALE_W-1:0] tickCnt;
  logic                  tick;
  logic [3:0]            sampleCnt;
  logic                  voteA, voteB;
  logic                  slow;
  logic [3:0]            nBitsM1;
  logic                  parEn, parOdd, nineBit;
  logic [3:0]            bitIdx;
  logic [3:0]            decidePt, lastPt;
  logic                  majority, decideNow, endNow;
  logic [3:0]            sizeBitsM1;

  assign lineNow  = syncReg[1];
  assign linePrev = syncReg[2];
  assign fallEdge = linePrev & ~lineNow;
  assign tick     = (tickCnt == '0);

  assign decidePt = slow ? 4'd9 : 4'd3;
  assign lastPt   = slow ? 4'd15 : 4'd7;
  assign majority = slow ? ((voteA & voteB) | (voteA & lineNow) | (voteB & lineNow)) : lineNow;
  assign decideNow = (state != S_IDLE) && tick && (sampleCnt == decidePt);
  assign endNow    = (state != S_IDLE) && tick && (sampleCnt == lastPt);

  always_comb begin
    if (sizeSel <= 3'd3)      sizeBitsM1 = {1'b0, sizeSel} + 4'd4;
    else if (sizeSel == 3'd4) sizeBitsM1 = 4'd8;
    else                      sizeBitsM1 = 4'd7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncReg <= 3'b111;
    else        syncReg <= {syncReg[1:0], rxLine};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tickCnt   <= '0;
      sampleCnt <= '0;
      voteA     <= 1'b1;
      voteB     <= 1'b1;
      slow      <= 1'b1;
      nBitsM1   <= 4'd7;
      parEn     <= 1'b0;
      parOdd    <= 1'b0;
      nineBit   <= 1'b0;
      bitIdx    <= '0;
    end else if (!rxEnable) begin
      state <= S_IDLE;
    end else if (state == S_IDLE) begin
      if (fallEdge) begin
        state     <= S_START;
        tickCnt   <= prescale;
        sampleCnt <= '0;
        slow      <= ~doubleSpeed;
        nBitsM1   <= sizeBitsM1;
        parEn     <= parityMode[1];
        parOdd    <= parityMode[0];
        nineBit   <= (sizeSel == 3'd4);
      end
    end else begin
      if (tick) begin
        tickCnt   <= prescale;
        sampleCnt <= (sampleCnt == lastPt) ? 4'd0 : sampleCnt + 4'd1;
        if (sampleCnt == 4'd7) voteA <= lineNow;
        if (sampleCnt == 4'd8) voteB <= lineNow;
      end else begin
        tickCnt <= tickCnt - 1'b1;
      end
      case (state)
        S_START: begin
          if (decideNow && majority) state <= S_IDLE;
          else if (endNow) begin
            state  <= S_DATA;
            bitIdx <= '0;
          end
        end
        S_DATA: begin
          if (endNow) begin
            if (bitIdx == nBitsM1) state <= parEn ? S_PARITY : S_STOP;
            else                   bitIdx <= bitIdx + 4'd1;
          end
        end
        S_PARITY: if (endNow) state <= S_STOP;
        S_STOP:   if (decideNow) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.startOk = rxEnable && (state == S_START)  && decideNow && !majority;
    stb.dataStb = rxEnable && (state == S_DATA)   && decideNow;
    stb.parStb  = rxEnable && (state == S_PARITY) && decideNow;
    stb.stopStb = rxEnable && (state == S_STOP)   && decideNow;
    stb.bitVal  = majority;
    stb.bitIdx  = bitIdx;
    stb.parEn   = parEn;
    stb.parOdd  = parOdd;
    stb.nineBit = nineBit;
  end

  // R5
  fast_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !slow) |-> (sampleCnt < 4'd8));

  // R2
  data_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (bitIdx <= nBitsM1));

endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rx_strobe_t stb,
  input  logic       addrFilter,
  input  logic       readStrobe,
  output rx_entry_t  headEntry,
  output logic       notEmpty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_entry_t         mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic [8:0]        shiftReg;
  logic              parAcc, peFlag;
  logic              lostFrame, ovrPending;
  rx_entry_t         holdData, holdDataNext, newEntry, pushData;
  logic              holdValid, holdNext;
  logic              accept, storeNow, pop, roomAfterPop, pushEn, overrunNow;

  assign accept     = !addrFilter || (stb.nineBit && shiftReg[8]);
  assign storeNow   = stb.stopStb && accept && !lostFrame;
  assign pop        = readStrobe && (count != '0);
  assign roomAfterPop = (count != CNT_W'(DEPTH)) || pop;
  assign overrunNow = stb.startOk && holdValid && (count == CNT_W'(DEPTH));

  always_comb begin
    newEntry.data = shiftReg;
    newEntry.fe   = ~stb.bitVal;
    newEntry.pe   = peFlag;
    newEntry.ovr  = ovrPending;
  end

  always_comb begin
    pushEn       = 1'b0;
    pushData     = newEntry;
    holdNext     = holdValid;
    holdDataNext = holdData;
    if (holdValid && roomAfterPop) begin
      pushEn   = 1'b1;
      pushData = holdData;
      if (storeNow) holdDataNext = newEntry;
      else          holdNext     = 1'b0;
    end else if (storeNow) begin
      if (roomAfterPop) pushEn = 1'b1;
      else begin
        holdNext     = 1'b1;
        holdDataNext = newEntry;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg   <= '0;
      parAcc     <= 1'b0;
      peFlag     <= 1'b0;
      lostFrame  <= 1'b0;
      ovrPending <= 1'b0;
    end else begin
      if (stb.startOk) begin
        shiftReg  <= '0;
        parAcc    <= 1'b0;
        peFlag    <= 1'b0;
        lostFrame <= overrunNow;
      end
      if (stb.dataStb) begin
        shiftReg[stb.bitIdx] <= stb.bitVal;
        parAcc <= parAcc ^ stb.bitVal;
      end
      if (stb.parStb)
        peFlag <= stb.parEn & (parAcc ^ stb.bitVal ^ stb.parOdd);
      if (overrunNow)    ovrPending <= 1'b1;
      else if (storeNow) ovrPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      count     <= '0;
      holdValid <= 1'b0;
      holdData  <= '0;
    end else begin
      holdValid <= holdNext;
      holdData  <= holdDataNext;
      if (pushEn) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)    rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(pushEn) - CNT_W'(pop);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (pushEn && wrPtr == PTR_W'(g))       mem[g] <= pushData;
    end
  end

  assign headEntry = mem[rdPtr];
  assign notEmpty  = (count != '0);

  // R7
  hold_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdValid |-> (count == CNT_W'(DEPTH)));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R8
  overrun_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.startOk && holdValid && count == CNT_W'(DEPTH)) |=> ovrPending);

  // R12
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readStrobe && count == '0 && !storeNow) |=> (count == '0));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.startOk, stb.dataStb, stb.parStb, stb.stopStb}));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import rxs_pkg::*;
#(
  parameter int PRESCALE_W = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rxLine,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic                  rxEnable,
  input  logic [1:0]            parityMode,
  input  logic [2:0]            sizeSel,
  input  logic                  doubleSpeed,
  input  logic                  addrFilter,
  input  logic                  rxIntEnable,
  input  logic                  globalIntEnable,
  input  logic                  readStrobe,
  output logic [7:0]            rxData,
  output logic                  rxBit9,
  output logic                  frameErr,
  output logic                  parityErr,
  output logic                  overrun,
  output logic                  dataAvail,
  output logic                  rxIrq
);

  rx_strobe_t stb;
  rx_entry_t  headEntry;
  logic       notEmpty;

  rxs_ctrl #(.PRESCALE_W(PRESCALE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .prescale(prescale),
    .rxEnable(rxEnable), .parityMode(parityMode), .sizeSel(sizeSel),
    .doubleSpeed(doubleSpeed), .stb(stb)
  );

  rxs_datapath #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .addrFilter(addrFilter),
    .readStrobe(readStrobe), .headEntry(headEntry), .notEmpty(notEmpty)
  );

  assign dataAvail = notEmpty;
  assign rxData    = notEmpty ? headEntry.data[7:0] : 8'h00;
  assign rxBit9    = notEmpty & headEntry.data[8];
  assign frameErr  = notEmpty & headEntry.fe;
  assign parityErr = notEmpty & headEntry.pe;
  assign overrun   = notEmpty & headEntry.ovr;
  assign rxIrq     = rxIntEnable & globalIntEnable & notEmpty;

endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        rxLine = 1'b1;
  logic [15:0] prescale = 16'd1;
  logic        rxEnable = 1'b1;
  logic [1:0]  parityMode = 2'd0;
  logic [2:0]  sizeSel = 3'd3;
  logic        doubleSpeed = 1'b0;
  logic        addrFilter = 1'b0;
  logic        rxIntEnable = 1'b0;
  logic        globalIntEnable = 1'b0;
  logic        readStrobe = 1'b0;
  logic [7:0]  rxData;
  logic        rxBit9, frameErr, parityErr, overrun, dataAvail, rxIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  uart_rx_status u_dut (
    .clk(clk), .rst_n(rst_n), .rxLine(rxLine), .prescale(prescale),
    .rxEnable(rxEnable), .parityMode(parityMode), .sizeSel(sizeSel),
    .doubleSpeed(doubleSpeed), .addrFilter(addrFilter), .rxIntEnable(rxIntEnable),
    .globalIntEnable(globalIntEnable), .readStrobe(readStrobe), .rxData(rxData),
    .rxBit9(rxBit9), .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun),
    .dataAvail(dataAvail), .rxIrq(rxIrq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int bitClocks();
    return (int'(prescale) + 1) * (doubleSpeed ? 8 : 16);
  endfunction

  task automatic driveBit(input logic v, input int clks, input int readAt);
    for (int i = 0; i < clks; i++) begin
      @(negedge clk);
      rxLine     = v;
      readStrobe = (i == readAt);
    end
  endtask

  // nb data bits, pm parity mode (bit1 enable, bit0 odd)
  task automatic sendFrame(input logic [8:0] val, input int nb, input int pm,
                           input bit badStop, input bit badPar, input int readAt);
    int bc;
    logic p;
    bc = bitClocks();
    driveBit(1'b0, bc, -1);
    p = 1'b0;
    for (int b = 0; b < nb; b++) begin
      driveBit(val[b], bc, -1);
      p = p ^ val[b];
    end
    if (pm >= 2) driveBit(p ^ (pm == 3) ^ badPar, bc, -1);
    driveBit(!badStop, bc, readAt);
    driveBit(1'b1, bc, -1);
    readStrobe = 1'b0;
  endtask

  task automatic readCheck(input logic [8:0] val, input int nb, input bit fe,
                           input bit pe, input bit ov, input string req);
    logic [8:0] m;
    m = val & 9'((1 << nb) - 1);
    @(negedge clk);
    chk(dataAvail == 1'b1, {req, " avail"}, int'(dataAvail), 1);
    chk(rxData == m[7:0], {req, " data"}, int'(rxData), int'(m[7:0]));
    chk(rxBit9 == ((nb == 9) ? m[8] : 1'b0), {req, " bit9"}, int'(rxBit9), int'(m[8]));
    chk(frameErr == fe, {req, " frameErr"}, int'(frameErr), int'(fe));
    chk(parityErr == pe, {req, " parityErr"}, int'(parityErr), int'(pe));
    chk(overrun == ov, {req, " overrun"}, int'(overrun), int'(ov));
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic expectEmpty(input string req);
    @(negedge clk);
    chk(dataAvail == 1'b0, req, int'(dataAvail), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({dataAvail, rxIrq, frameErr, parityErr, overrun, rxBit9} == 6'd0, "R1 flags", 0, 0);
    chk(rxData == 8'h00, "R1 data", int'(rxData), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5 sweep: sizes, parity modes, speeds, patterns
    for (int sel = 0; sel < 5; sel++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int ds = 0; ds < 2; ds++) begin
          for (int k = 0; k < 4; k++) begin
            int pm;
            logic [8:0] v;
            bit bs, bp;
            pm = (pi == 0) ? 0 : pi + 1;
            sizeSel = 3'(sel);
            parityMode = 2'(pm);
            doubleSpeed = ds[0];
            v = 9'((k * 91 + sel * 37 + pi * 13 + ds * 5 + 1) % 512);
            bs = (k == 3);
            bp = (k == 2) && (pm != 0);
            sendFrame(v, sel + 5, pm, bs, bp, -1);
            readCheck(v, sel + 5, bs, bp, 1'b0, "R2 R3 R4 R5 sweep");
          end
        end
      end
    end

    // R5 slower prescaler
    prescale = 16'd3; sizeSel = 3'd3; parityMode = 2'd3; doubleSpeed = 1'b0;
    sendFrame(9'h0C3, 8, 3, 1'b0, 1'b0, -1);
    readCheck(9'h0C3, 8, 1'b0, 1'b0, 1'b0, "R5 prescale3");
    prescale = 16'd1; parityMode = 2'd0;

    // R12 read while empty
    expectEmpty("R12 before");
    readStrobe = 1'b1; @(negedge clk); readStrobe = 1'b0;
    expectEmpty("R12 after read");
    sendFrame(9'h05A, 8, 0, 1'b0, 1'b0, -1);
    readCheck(9'h05A, 8, 1'b0, 1'b0, 1'b0, "R12 recovery");
    expectEmpty("R12 drained");

    // R10 interrupt combinations
    sendFrame(9'h011, 8, 0, 1'b0, 1'b0, -1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      rxIntEnable = c[0]; globalIntEnable = c[1];
      @(negedge clk);
      chk(rxIrq == (c == 3), "R10 irq with data", int'(rxIrq), int'(c == 3));
    end
    readCheck(9'h011, 8, 1'b0, 1'b0, 1'b0, "R10 read");
    @(negedge clk);
    chk(rxIrq == 1'b0, "R10 irq empty", int'(rxIrq), 0);
    rxIntEnable = 1'b0; globalIntEnable = 1'b0;

    // R6 R7 R8 queue, holding register, overrun
    sendFrame(9'h0A1, 8, 0, 1'b0, 1'b0, -1);
    sendFrame(9'h0B2, 8, 1'b0 ? 1 : 0, 1'b1, 1'b0, -1);
    sendFrame(9'h0C3, 8, 0, 1'b0, 1'b0, -1);
    sendFrame(9'h0D4, 8, 0, 1'b0, 1'b0, -1);
    readCheck(9'h0A1, 8, 1'b0, 1'b0, 1'b0, "R6 R8 head intact");
    readCheck(9'h0B2, 8, 1'b1, 1'b0, 1'b0, "R6 own flags");
    readCheck(9'h0C3, 8, 1'b0, 1'b0, 1'b0, "R7 held char");
    expectEmpty("R8 lost char not stored");
    sendFrame(9'h0E5, 8, 0, 1'b0, 1'b0, -1);
    readCheck(9'h0E5, 8, 1'b0, 1'b0, 1'b1, "R8 overrun mark");
    sendFrame(9'h0F6, 8, 0, 1'b0, 1'b0, -1);
    readCheck(9'h0F6, 8, 1'b0, 1'b0, 1'b0, "R8 overrun cleared");

    // R7 read coinciding with frame completion, swept across stop bit
    for (int off = 0; off < 32; off++) begin
      logic [8:0] b, c3;
      b  = 9'(16 + off);
      c3 = 9'(128 + off);
      sendFrame(9'h033, 8, 0, 1'b0, 1'b0, -1);
      sendFrame(b, 8, 0, 1'b0, 1'b0, -1);
      sendFrame(c3, 8, 0, 1'b0, 1'b0, off);
      readCheck(b, 8, 1'b0, 1'b0, 1'b0, "R7 same-cycle second");
      readCheck(c3, 8, 1'b0, 1'b0, 1'b0, "R7 same-cycle third");
      expectEmpty("R7 same-cycle drained");
    end

    // R9 address filter
    addrFilter = 1'b1; sizeSel = 3'd4;
    sendFrame(9'h0A5, 9, 0, 1'b0, 1'b0, -1);
    expectEmpty("R9 data frame dropped");
    sendFrame(9'h1A5, 9, 0, 1'b0, 1'b0, -1);
    readCheck(9'h1A5, 9, 1'b0, 1'b0, 1'b0, "R9 address accepted");
    sizeSel = 3'd3;
    sendFrame(9'h03C, 8, 0, 1'b0, 1'b0, -1);
    expectEmpty("R9 8-bit dropped");
    addrFilter = 1'b0;

    // R11 glitch
    driveBit(1'b0, bitClocks() / 4, -1);
    driveBit(1'b1, bitClocks() * 2, -1);
    expectEmpty("R11 glitch ignored");
    sendFrame(9'h069, 8, 0, 1'b0, 1'b0, -1);
    readCheck(9'h069, 8, 1'b0, 1'b0, 1'b0, "R11 after glitch");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule